// File: doc/BRIEF.md
# Per-Bank Parity Error Responder

This block sits beside a memory controller's read path and decides what happens when externally checked parity goes wrong on a local read. Parity bits are produced and compared outside the block; the outside logic only raises an error strobe during a read data beat. The block combines that strobe with the bank being read, the bank's width and the agent that started the read (processor, DMA engine or PCI target), and with a per-bank enable vector that says which banks carry parity at all.

A wide processor read from a parity bank gets a hint telling the processor to check parity itself, and the block raises nothing of its own for it. Every other read from a parity bank is policed by the block. A narrow processor read returns its data with an error flag. A DMA read records a cause. A PCI read pulses a system-error line. Each of these also records a sticky cause bit. The cause bits drive one interrupt line through a mask and are cleared by writing ones.

The per-beat outputs are registered, so they appear in the cycle after the beat, lined up with the data that the controller returns one cycle later.

Top module: `par_err_responder`

## Requirements
- R1: For a valid beat with `rd_src`=0 (processor), `rd_wide`=1 and the bank's `par_en` bit set, `cpu_chk_hint` is 1 in the next cycle. `cpu_data_err` stays 0 and no cause bit is set, whatever `ext_err` is.
- R2: For a processor beat with `rd_wide`=0, `cpu_chk_hint` is 0 in the next cycle, even when the bank's `par_en` bit is set.
- R3: For a valid processor beat with `rd_wide`=0, the bank enabled and `ext_err`=1, `cpu_data_err` is 1 in the next cycle and cause bit 0 becomes set.
- R4: For a valid beat with `rd_src`=1 (DMA), the bank enabled and `ext_err`=1, cause bit 1 becomes set in the next cycle. `pci_serr` and `cpu_data_err` stay 0.
- R5: For a valid beat with `rd_src`=2 (PCI), the bank enabled and `ext_err`=1, `pci_serr` is 1 for exactly the next cycle and cause bit 2 becomes set. Back-to-back erroneous beats give one pulse each.
- R6: A beat from a bank whose `par_en` bit is 0 produces no hint, no data error, no system error and no cause change. An `rd_src` value of 3 likewise produces nothing.
- R7: While `rd_valid`=0, `ext_err` and the other read inputs have no effect on any output or cause bit.
- R8: Cause bits are sticky. A 1 in bit i of `cause_clr` clears cause bit i at the next edge. If a bit is set and cleared in the same cycle, it ends up set.
- R9: `irq` is 1 exactly when some cause bit is set whose `irq_mask` bit is 0 (mask bit 1 = masked). The cause bits themselves ignore the mask.
- R10: After synchronous reset, `cpu_chk_hint`, `cpu_data_err`, `pci_serr`, `cause` and `irq` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| par_en | input | NUM_BANKS | Per-bank parity-present enables |
| rd_valid | input | 1 | Read data beat qualifier |
| rd_src | input | 2 | Read initiator: 0 processor, 1 DMA, 2 PCI, 3 reserved |
| rd_bank | input | clog2(NUM_BANKS) | Bank being read |
| rd_wide | input | 1 | 1 = 64-bit bank, 0 = 32-bit bank |
| ext_err | input | 1 | Parity error strobe from external checker |
| cause_clr | input | 3 | Write-one-to-clear strobes for cause bits |
| irq_mask | input | 3 | Interrupt mask per cause, 1 = masked |
| cpu_chk_hint | output | 1 | Tells processor to check parity on this beat |
| cpu_data_err | output | 1 | Error flag on returned processor data |
| pci_serr | output | 1 | One-cycle PCI system-error pulse |
| cause | output | 3 | Sticky causes: bit0 processor, bit1 DMA, bit2 PCI |
| irq | output | 1 | Parity interrupt |

## Verification
The assertions assume the read inputs are steady across the edge that samples a beat. They also assume `rd_bank` stays below NUM_BANKS, so the enable lookup is always defined. The stimulus changes every input on the falling edge only and draws bank numbers from the four banks that exist. Cause clears are driven as a single-cycle strobe together with an ordinary beat, so the set-and-clear collision of R8 arises only where a test asks for it.

// File: rtl/prr_pkg.sv
package prr_pkg;

    localparam int NCAUSE = 3;

    localparam int CZ_CPU = 0;
    localparam int CZ_DMA = 1;
    localparam int CZ_PCI = 2;

    typedef enum logic [1:0] {
        SRC_CPU = 2'd0,
        SRC_DMA = 2'd1,
        SRC_PCI = 2'd2,
        SRC_RSV = 2'd3
    } rd_src_e;

    typedef struct packed {
        logic              hint;
        logic              data_err;
        logic              serr;
        logic [NCAUSE-1:0] cause_set;
    } resp_t;

    localparam resp_t RESP_NONE = '{hint: 1'b0, data_err: 1'b0, serr: 1'b0, cause_set: '0};

    function automatic logic [NCAUSE-1:0] cause_bit(input int idx);
        logic [NCAUSE-1:0] v;
        v = '0;
        v[idx] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/prr_decode.sv
module prr_decode
    import prr_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [NUM_BANKS-1:0] par_en,
    input  logic                 rd_valid,
    input  logic [1:0]           rd_src,
    input  logic [BANK_W-1:0]    rd_bank,
    input  logic                 rd_wide,
    input  logic                 ext_err,
    output resp_t                resp
);

    logic bank_on;

    always_comb begin
        bank_on = par_en[rd_bank];
    end

    always_comb begin
        resp = RESP_NONE;
        if (rd_valid && bank_on) begin
            case (rd_src_e'(rd_src))
                SRC_CPU: begin
                    if (rd_wide) begin
                        resp.hint = 1'b1;
                    end else if (ext_err) begin
                        resp.data_err  = 1'b1;
                        resp.cause_set = cause_bit(CZ_CPU);
                    end
                end
                SRC_DMA: begin
                    if (ext_err) begin
                        resp.cause_set = cause_bit(CZ_DMA);
                    end
                end
                SRC_PCI: begin
                    if (ext_err) begin
                        resp.serr      = 1'b1;
                        resp.cause_set = cause_bit(CZ_PCI);
                    end
                end
                default: resp = RESP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/prr_beat_reg.sv
module prr_beat_reg
    import prr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  resp_t resp_d,
    output logic  hint_q,
    output logic  data_err_q,
    output logic  serr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hint_q     <= 1'b0;
            data_err_q <= 1'b0;
            serr_q     <= 1'b0;
        end else begin
            hint_q     <= resp_d.hint;
            data_err_q <= resp_d.data_err;
            serr_q     <= resp_d.serr;
        end
    end

    // R5: a system-error pulse never outlasts its beat unless the next beat also errs
    a_r5_serr_single: assert property (@(posedge clk) disable iff (rst)
        (serr_q && !resp_d.serr) |=> !serr_q);

    // R1: hint and data error are never raised together
    a_r1_hint_excl: assert property (@(posedge clk) disable iff (rst)
        !(hint_q && data_err_q));

endmodule

// File: rtl/prr_cause_reg.sv
module prr_cause_reg
    import prr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCAUSE-1:0] set_i,
    input  logic [NCAUSE-1:0] clr_i,
    input  logic [NCAUSE-1:0] mask_i,
    output logic [NCAUSE-1:0] cause_q,
    output logic              irq_o
);

    logic [NCAUSE-1:0] cause_d;
    logic [NCAUSE-1:0] live;

    always_comb begin
        cause_d = (cause_q & ~clr_i) | set_i;
        live    = cause_q & ~mask_i;
        irq_o   = |live;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= '0;
        end else begin
            cause_q <= cause_d;
        end
    end

    // R8: a set cause survives unless its clear strobe is given
    a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((cause_q & $past(cause_q & ~clr_i)) == $past(cause_q & ~clr_i)));

    // R8: a new set wins over a simultaneous clear
    a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((cause_q & $past(set_i)) == $past(set_i)));

    // R9: all causes masked keeps the interrupt low
    a_r9_all_masked: assert property (@(posedge clk) disable iff (rst)
        (&mask_i) |-> !irq_o);

endmodule

// File: rtl/par_err_responder.sv
module par_err_responder
    import prr_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_BANKS-1:0] par_en,
    input  logic                 rd_valid,
    input  logic [1:0]           rd_src,
    input  logic [BANK_W-1:0]    rd_bank,
    input  logic                 rd_wide,
    input  logic                 ext_err,
    input  logic [2:0]           cause_clr,
    input  logic [2:0]           irq_mask,
    output logic                 cpu_chk_hint,
    output logic                 cpu_data_err,
    output logic                 pci_serr,
    output logic [2:0]           cause,
    output logic                 irq
);

    resp_t resp;

    prr_decode #(.NUM_BANKS(NUM_BANKS)) u_decode (
        .par_en   (par_en),
        .rd_valid (rd_valid),
        .rd_src   (rd_src),
        .rd_bank  (rd_bank),
        .rd_wide  (rd_wide),
        .ext_err  (ext_err),
        .resp     (resp)
    );

    prr_beat_reg u_beat (
        .clk        (clk),
        .rst        (rst),
        .resp_d     (resp),
        .hint_q     (cpu_chk_hint),
        .data_err_q (cpu_data_err),
        .serr_q     (pci_serr)
    );

    prr_cause_reg u_cause (
        .clk     (clk),
        .rst     (rst),
        .set_i   (resp.cause_set),
        .clr_i   (cause_clr),
        .mask_i  (irq_mask),
        .cause_q (cause),
        .irq_o   (irq)
    );

    // R1: wide processor read from a parity bank hands checking to the processor
    a_r1_wide_hint: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_src == 2'd0 && rd_wide && par_en[rd_bank])
        |=> (cpu_chk_hint && !cpu_data_err));

    // R2: narrow processor read never hints
    a_r2_narrow_no_hint: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_src == 2'd0 && !rd_wide) |=> !cpu_chk_hint);

    // R3: narrow processor read with error flags data and records cause 0
    a_r3_narrow_err: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_src == 2'd0 && !rd_wide && par_en[rd_bank] && ext_err)
        |=> (cpu_data_err && cause[0]));

    // R4: DMA error records cause 1 without the other strobes
    a_r4_dma_err: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_src == 2'd1 && par_en[rd_bank] && ext_err)
        |=> (cause[1] && !pci_serr && !cpu_data_err));

    // R5: PCI error pulses system error and records cause 2
    a_r5_pci_err: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_src == 2'd2 && par_en[rd_bank] && ext_err)
        |=> (pci_serr && cause[2]));

    // R6: a bank without parity produces no per-beat response
    a_r6_bank_off: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !par_en[rd_bank])
        |=> (!cpu_chk_hint && !cpu_data_err && !pci_serr));

    // R7: no beat, no response
    a_r7_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_valid |=> (!cpu_chk_hint && !cpu_data_err && !pci_serr));

    // R10: outputs quiet right after reset
    a_r10_reset: assert property (@(posedge clk)
        $past(rst) |-> (!cpu_chk_hint && !cpu_data_err && !pci_serr && cause == 3'b000));

endmodule

// File: tb/sim_par_err_responder.sv
module sim_par_err_responder;

    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic [NB-1:0] par_en;
    logic          rd_valid;
    logic [1:0]    rd_src;
    logic [1:0]    rd_bank;
    logic          rd_wide;
    logic          ext_err;
    logic [2:0]    cause_clr;
    logic [2:0]    irq_mask;
    logic          cpu_chk_hint, cpu_data_err, pci_serr, irq;
    logic [2:0]    cause;

    always #2 clk = ~clk;

    par_err_responder #(.NUM_BANKS(NB)) u0 (
        .clk(clk), .rst(rst), .par_en(par_en), .rd_valid(rd_valid),
        .rd_src(rd_src), .rd_bank(rd_bank), .rd_wide(rd_wide),
        .ext_err(ext_err), .cause_clr(cause_clr), .irq_mask(irq_mask),
        .cpu_chk_hint(cpu_chk_hint), .cpu_data_err(cpu_data_err),
        .pci_serr(pci_serr), .cause(cause), .irq(irq)
    );

    typedef struct {
        logic [6:0] exp;   // {hint, derr, serr, cause[2:0], irq}
        string      tag;
    } item_t;

    item_t       sb[$];
    int          n_cmp = 0;
    int          n_bad = 0;
    logic [2:0]  m_cause = 3'b000;
    bit          done = 0;

    // driver: applies one beat at the falling edge and pushes the expected result
    task automatic beat(input logic v, input logic [1:0] src, input int bank,
                        input logic wide, input logic err, input logic [2:0] clr,
                        input logic [2:0] mask, input string tag);
        logic on, h, d, s;
        logic [2:0] st;
        item_t it;
        @(negedge clk);
        rd_valid = v; rd_src = src; rd_bank = 2'(bank); rd_wide = wide;
        ext_err = err; cause_clr = clr; irq_mask = mask;
        on = v && par_en[bank];
        h  = on && src == 2'd0 && wide;
        d  = on && src == 2'd0 && !wide && err;
        s  = on && src == 2'd2 && err;
        st = {s, on && src == 2'd1 && err, d};
        m_cause = (m_cause & ~clr) | st;
        it.exp = {h, d, s, m_cause, |(m_cause & ~mask)};
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic idle(input logic [2:0] mask, input string tag);
        beat(1'b0, 2'd0, 0, 1'b0, 1'b1, 3'b000, mask, tag);
    endtask

    // monitor: one cycle after each beat, compare against the scoreboard
    always @(posedge clk) begin
        #1;
        if (sb.size() > 0) begin
            item_t it;
            logic [6:0] act;
            it  = sb.pop_front();
            act = {cpu_chk_hint, cpu_data_err, pci_serr, cause, irq};
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: got hint/derr/serr/cause/irq=%b expected %b", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        #100000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; par_en = 4'b0101; rd_valid = 0; rd_src = 0; rd_bank = 0;
        rd_wide = 0; ext_err = 0; cause_clr = 0; irq_mask = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        n_cmp++;
        if ({cpu_chk_hint, cpu_data_err, pci_serr, cause, irq} !== 7'b0) begin
            n_bad++;
            $display("FAIL R10: got %b expected 0000000", {cpu_chk_hint, cpu_data_err, pci_serr, cause, irq});
        end

        beat(1, 2'd0, 0, 1, 0, 3'b000, 3'b000, "R1 wide cpu no err");
        beat(1, 2'd0, 2, 1, 1, 3'b000, 3'b000, "R1 wide cpu with err");
        beat(1, 2'd0, 0, 0, 0, 3'b000, 3'b000, "R2 narrow cpu no err");
        beat(1, 2'd0, 2, 0, 1, 3'b000, 3'b000, "R3 narrow cpu err");
        idle(3'b000, "R3 cause stays");
        beat(1, 2'd0, 1, 0, 1, 3'b001, 3'b000, "R6 narrow cpu bank off, clear c0");
        beat(1, 2'd0, 3, 1, 1, 3'b000, 3'b000, "R6 wide cpu bank off");
        beat(1, 2'd1, 0, 0, 1, 3'b000, 3'b000, "R4 dma err");
        beat(1, 2'd1, 2, 1, 0, 3'b000, 3'b000, "R4 dma no err");
        beat(1, 2'd2, 2, 0, 1, 3'b000, 3'b000, "R5 pci err beat 1");
        beat(1, 2'd2, 0, 1, 1, 3'b000, 3'b000, "R5 pci err beat 2");
        idle(3'b000, "R5 pulse ends");
        beat(1, 2'd2, 1, 0, 1, 3'b000, 3'b000, "R6 pci bank off");
        beat(1, 2'd3, 0, 0, 1, 3'b000, 3'b000, "R6 reserved source");
        beat(0, 2'd0, 0, 0, 1, 3'b000, 3'b000, "R7 no valid narrow cpu");
        beat(0, 2'd2, 2, 0, 1, 3'b000, 3'b000, "R7 no valid pci");
        idle(3'b111, "R9 all masked");
        idle(3'b110, "R9 cause1 masked, cause2 masked");
        idle(3'b100, "R9 cause1 unmasked");
        beat(1, 2'd0, 0, 0, 1, 3'b100, 3'b011, "R8 clear c2 set c0");
        beat(1, 2'd1, 2, 0, 1, 3'b010, 3'b011, "R8 set wins over clear c1");
        idle(3'b100, "R9 irq from c0/c1");
        beat(0, 2'd0, 0, 0, 0, 3'b011, 3'b000, "R8 clear all");
        idle(3'b000, "R9 irq low after clear");
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule